// File: doc/BRIEF.md
# Output Fault Supervisor

This block sits between the register that holds the commanded switch states and the six power output stages of a driver chip. For every output it decides whether the stage may really conduct. It takes into account per-output overcurrent indicators, supply over-voltage and under-voltage indicators, thermal warning and shutdown indicators, a hardware inhibit pin and a software run bit. Fault delays are counted in ticks of a slow time-base input. A single select bit chooses between a long and a short delay for short-circuit and over-voltage faults.

The block also holds the sticky fault flags and assembles the 16-bit status word that a serial shifter elsewhere sends back to the host. A one-cycle status-reset pulse from the host clears the latched faults. Each fault class follows its own recovery rule. A short-circuit trip stays until a status reset. A supply trip ends as soon as the supply is good again, but its flag stays set until a status reset. A thermal shutdown needs the indicator to clear first and a status reset after that.

Top module: `drv_fault_supervisor`

## Requirements
- R1: An output whose overcurrent indicator stays high through the full short-circuit delay is disabled from the clock edge that takes the last tick. Only that output is disabled, and status bit 13 goes high. If the indicator drops before the delay ends, the count restarts from zero.
- R2: The short-circuit delay is SC_TICKS ticks when `dly_long` is low and 8×SC_TICKS ticks when it is high.
- R3: If `tp_warn` and an output's overcurrent indicator are high in the same cycle, that output is disabled at the next clock edge and status bit 13 is set, with no delay.
- R4: An over-voltage indication that lasts OV_TICKS ticks (4×OV_TICKS when `dly_long` is high) sets status bit 15 and disables all outputs.
- R5: An under-voltage indication that lasts UV_TICKS ticks sets status bit 15 and disables all outputs, whatever the value of `dly_long`.
- R6: Outputs disabled by a supply fault are enabled again on the clock edge after the supply indicator goes low. Bit 15 stays set until a status reset. A status reset during an ongoing supply fault clears bit 15, and the bit is set again once a full delay has elapsed.
- R7: From the edge that samples `tsd_det` high, all outputs are off and the status word is 16'hFFFF. This holds until a status reset arrives in a cycle where `tsd_det` is low.
- R8: A status reset clears bits 13 and 15 and re-enables outputs disabled by a short. If the overcurrent is still present, a new full delay must elapse before the output trips and bit 13 sets again.
- R9: If `hw_run` or `sw_run` is low, every output is off and status bit 14 reads 1. Otherwise bit 14 reads 0.
- R10: Status bit 0 is `tp_warn` and bits 12 to 7 are 0. Bit i+1 is 1 when output i is enabled. When output i is off, bit i+1 follows `open_ld[i]` if `ol_test_n` is low and `sw_run` is high, and is 0 otherwise.
- R11: `ol_src_en[i]` is high exactly when `ol_test_n` is low, `sw_run` is high and output i is not enabled.
- R12: After reset no flag is set, the status word is 0 when no output is commanded, and `drv_en` follows `cmd_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle time-base pulse for the delay counters |
| cmd_on | input | 6 | Commanded switch state per output |
| ovc | input | 6 | Overcurrent indicator per output |
| ov_det | input | 1 | Supply over-voltage indicator |
| uv_det | input | 1 | Supply under-voltage indicator |
| tp_warn | input | 1 | Thermal prewarning indicator |
| tsd_det | input | 1 | Thermal shutdown indicator |
| hw_run | input | 1 | Hardware inhibit pin, low = standby |
| sw_run | input | 1 | Software run bit, low = standby |
| ol_test_n | input | 1 | Open-load test request, active low |
| open_ld | input | 6 | Open-load comparator per output |
| dly_long | input | 1 | Selects the long fault delays |
| srr | input | 1 | Status reset pulse |
| drv_en | output | 6 | Actual enable per output stage |
| ol_src_en | output | 6 | Open-load test current enable per output |
| status | output | 16 | Assembled status word |

## Verification
The checker checks these rules on every cycle: the inhibit and supply-hold gating, the thermal override of the status word, the clearing effect of a status reset, the immediate trip under thermal warning, the zero reserved bits, and the mutual exclusion of open-load current with an enabled output. The exact tick count at which each delay expires, the restart of a count when the fault drops early, the factor chosen by the select bit, and the re-trip after a reset during a persisting fault depend on history. The bench's timed scenarios show these. They run for every output and both select values, beside an exhaustive sweep of the status and open-load logic.

// File: rtl/drv_sup_pkg.sv
package drv_sup_pkg;

  // Status word layout, decoded by the serial shifter next door
  localparam int unsigned CH_N    = 6;
  localparam int unsigned TP_BIT  = 0;
  localparam int unsigned CH_LSB  = 1;
  localparam int unsigned SCD_BIT = 13;
  localparam int unsigned INH_BIT = 14;
  localparam int unsigned PSF_BIT = 15;
  localparam int unsigned ST_W    = 16;

  // Long/short delay ratios
  localparam int unsigned SC_RATIO = 8;
  localparam int unsigned OV_RATIO = 4;

  function automatic int unsigned pick_limit(logic sel_long, int unsigned base,
                                             int unsigned ratio);
    return sel_long ? base * ratio : base;
  endfunction

  // True when the tick in progress is the one that completes the delay
  function automatic logic last_tick(int unsigned cnt, int unsigned limit);
    return (cnt + 1) >= limit;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic logic [ST_W-1:0] build_status(logic tp, logic [CH_N-1:0] ch,
                                                   logic scd, logic inh, logic psf,
                                                   logic tsd);
    logic [ST_W-1:0] s;
    s = '0;
    s[TP_BIT]          = tp;
    s[CH_LSB +: CH_N]  = ch;
    s[SCD_BIT]         = scd;
    s[INH_BIT]         = inh;
    s[PSF_BIT]         = psf;
    if (tsd) s = '1;
    return s;
  endfunction

endpackage

// File: rtl/drv_dly_timer.sv
module drv_dly_timer
  import drv_sup_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;
  logic         done;

  always_comb
    hit = run && !clr && tick && !done && last_tick(32'(cnt), 32'(limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (clr || !run) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (tick && !done) begin
      cnt <= cnt + 1'b1;
      if (hit) done <= 1'b1;
    end
  end
endmodule

// File: rtl/drv_chan_guard.sv
module drv_chan_guard #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ovc,
  input  logic         tp_warn,
  input  logic         srr,
  input  logic [W-1:0] limit,
  output logic         sc_off,
  output logic         trip
);
  logic run, hit, fast;

  assign run  = ovc && !sc_off;
  assign fast = ovc && tp_warn && !sc_off && !srr;
  assign trip = hit || fast;

  drv_dly_timer #(.W(W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .clr   (srr),
    .tick  (tick),
    .limit (limit),
    .hit   (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sc_off <= 1'b0;
    else if (srr)   sc_off <= 1'b0;
    else if (trip)  sc_off <= 1'b1;
  end
endmodule

// File: rtl/drv_supply_guard.sv
module drv_supply_guard #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ov_det,
  input  logic         uv_det,
  input  logic         srr,
  input  logic [W-1:0] ov_limit,
  input  logic [W-1:0] uv_limit,
  output logic         sup_off,
  output logic         psf
);
  logic [1:0]   det, hit, hold;
  logic [W-1:0] lim [2];

  assign det    = {uv_det, ov_det};
  assign lim[0] = ov_limit;
  assign lim[1] = uv_limit;

  for (genvar r = 0; r < 2; r++) begin : g_rail
    drv_dly_timer #(.W(W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (det[r]),
      .clr   (srr),
      .tick  (tick),
      .limit (lim[r]),
      .hit   (hit[r])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hold[r] <= 1'b0;
      else if (!det[r]) hold[r] <= 1'b0;
      else if (hit[r])  hold[r] <= 1'b1;
    end
  end

  assign sup_off = |hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    psf <= 1'b0;
    else if (srr)  psf <= 1'b0;
    else if (|hit) psf <= 1'b1;
  end
endmodule

// File: rtl/drv_status_pack.sv
module drv_status_pack
  import drv_sup_pkg::*;
(
  input  logic            tp_warn,
  input  logic [CH_N-1:0] drv_en,
  input  logic [CH_N-1:0] open_ld,
  input  logic            ol_en,
  input  logic            scd,
  input  logic            inh,
  input  logic            psf,
  input  logic            tsd_lat,
  output logic [CH_N-1:0] ol_src_en,
  output logic [ST_W-1:0] status
);
  logic [CH_N-1:0] ch_bits;

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    assign ol_src_en[i] = ol_en && !drv_en[i];
    assign ch_bits[i]   = drv_en[i] | (ol_src_en[i] & open_ld[i]);
  end

  assign status = build_status(tp_warn, ch_bits, scd, inh, psf, tsd_lat);
endmodule

// File: rtl/drv_fault_supervisor.sv
module drv_fault_supervisor
  import drv_sup_pkg::*;
#(
  parameter int unsigned SC_TICKS = 25,
  parameter int unsigned OV_TICKS = 7,
  parameter int unsigned UV_TICKS = 28
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [CH_N-1:0] cmd_on,
  input  logic [CH_N-1:0] ovc,
  input  logic            ov_det,
  input  logic            uv_det,
  input  logic            tp_warn,
  input  logic            tsd_det,
  input  logic            hw_run,
  input  logic            sw_run,
  input  logic            ol_test_n,
  input  logic [CH_N-1:0] open_ld,
  input  logic            dly_long,
  input  logic            srr,
  output logic [CH_N-1:0] drv_en,
  output logic [CH_N-1:0] ol_src_en,
  output logic [ST_W-1:0] status
);
  localparam int unsigned MAX_T = max3(SC_TICKS * SC_RATIO, OV_TICKS * OV_RATIO, UV_TICKS);
  localparam int unsigned TW    = $clog2(MAX_T + 1);

  logic [TW-1:0]   sc_lim, ov_lim, uv_lim;
  logic [CH_N-1:0] sc_off, sc_trip;
  logic            sc_trip_any, scd, psf, sup_off, tsd_lat, inh, ol_en, global_off;

  assign sc_lim = TW'(pick_limit(dly_long, SC_TICKS, SC_RATIO));
  assign ov_lim = TW'(pick_limit(dly_long, OV_TICKS, OV_RATIO));
  assign uv_lim = TW'(UV_TICKS);

  for (genvar i = 0; i < CH_N; i++) begin : g_chan
    drv_chan_guard #(.W(TW)) u_guard (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .ovc     (ovc[i]),
      .tp_warn (tp_warn),
      .srr     (srr),
      .limit   (sc_lim),
      .sc_off  (sc_off[i]),
      .trip    (sc_trip[i])
    );
  end

  assign sc_trip_any = |sc_trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           scd <= 1'b0;
    else if (srr)         scd <= 1'b0;
    else if (sc_trip_any) scd <= 1'b1;
  end

  drv_supply_guard #(.W(TW)) u_supply (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .ov_det   (ov_det),
    .uv_det   (uv_det),
    .srr      (srr),
    .ov_limit (ov_lim),
    .uv_limit (uv_lim),
    .sup_off  (sup_off),
    .psf      (psf)
  );

  // Thermal latch: set while indicated, cleared only by a reset after it drops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tsd_lat <= 1'b0;
    else if (tsd_det) tsd_lat <= 1'b1;
    else if (srr)     tsd_lat <= 1'b0;
  end

  assign inh        = !hw_run || !sw_run;
  assign ol_en      = !ol_test_n && sw_run;
  assign global_off = inh || sup_off || tsd_lat;
  assign drv_en     = cmd_on & ~sc_off & {CH_N{!global_off}};

  drv_status_pack u_pack (
    .tp_warn   (tp_warn),
    .drv_en    (drv_en),
    .open_ld   (open_ld),
    .ol_en     (ol_en),
    .scd       (scd),
    .inh       (inh),
    .psf       (psf),
    .tsd_lat   (tsd_lat),
    .ol_src_en (ol_src_en),
    .status    (status)
  );
endmodule

// File: rtl/drv_fault_supervisor_chk.sv
module drv_fault_supervisor_chk
  import drv_sup_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            srr,
  input logic            tsd_det,
  input logic            tp_warn,
  input logic            hw_run,
  input logic            sw_run,
  input logic            ol_test_n,
  input logic [CH_N-1:0] ovc,
  input logic [CH_N-1:0] drv_en,
  input logic [CH_N-1:0] ol_src_en,
  input logic [ST_W-1:0] status,
  input logic            sup_off,
  input logic            tsd_lat,
  input logic            sc_trip_any
);
  a_r1_trip_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_trip_any && !srr) |=> status[SCD_BIT]);

  a_r3_warn_trips_now: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(ovc & {CH_N{tp_warn}})) && !srr) |=> status[SCD_BIT]);

  a_r6_supply_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    sup_off |-> (drv_en == '0));

  a_r7_thermal_override: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_det |=> ((status == '1) && (drv_en == '0)));

  a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (srr && !tsd_det) |=> (!status[SCD_BIT] && !status[PSF_BIT]));

  a_r9_inhibit_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_run || !sw_run) |-> ((drv_en == '0) && status[INH_BIT]));

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !tsd_lat |-> (status[SCD_BIT-1:CH_LSB+CH_N] == '0));

  a_r11_no_src_when_on: assert property (@(posedge clk) disable iff (!rst_n)
    ((ol_src_en & drv_en) == '0));

  a_r11_src_needs_test: assert property (@(posedge clk) disable iff (!rst_n)
    (|ol_src_en) |-> (sw_run && !ol_test_n));
endmodule

bind drv_fault_supervisor drv_fault_supervisor_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .srr         (srr),
  .tsd_det     (tsd_det),
  .tp_warn     (tp_warn),
  .hw_run      (hw_run),
  .sw_run      (sw_run),
  .ol_test_n   (ol_test_n),
  .ovc         (ovc),
  .drv_en      (drv_en),
  .ol_src_en   (ol_src_en),
  .status      (status),
  .sup_off     (sup_off),
  .tsd_lat     (tsd_lat),
  .sc_trip_any (sc_trip_any)
);

// File: tb/drv_fault_supervisor_bench.sv
module drv_fault_supervisor_bench;
  localparam int SC = 3;
  localparam int OV = 2;
  localparam int UV = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [5:0]  cmd_on = '0, ovc = '0, open_ld = '0;
  logic        ov_det = 0, uv_det = 0, tp_warn = 0, tsd_det = 0;
  logic        hw_run = 1, sw_run = 1, ol_test_n = 1, dly_long = 0, srr = 0;
  logic [5:0]  drv_en, ol_src_en;
  logic [15:0] status;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  drv_fault_supervisor #(.SC_TICKS(SC), .OV_TICKS(OV), .UV_TICKS(UV)) u_drv_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_on(cmd_on), .ovc(ovc),
    .ov_det(ov_det), .uv_det(uv_det), .tp_warn(tp_warn), .tsd_det(tsd_det),
    .hw_run(hw_run), .sw_run(sw_run), .ol_test_n(ol_test_n), .open_ld(open_ld),
    .dly_long(dly_long), .srr(srr), .drv_en(drv_en), .ol_src_en(ol_src_en),
    .status(status)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic pulse_srr();
    srr = 1'b1;
    @(negedge clk);
    srr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 status after reset", status, 0);
    chk("R12 drv after reset", drv_en, 0);
    cmd_on = 6'h2D;
    #1 chk("R12 drv follows cmd", drv_en, 6'h2D);
    @(negedge clk);

    // R10/R11/R9: exhaustive status and open-load sweep
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 64; c++) begin
        for (int o = 0; o < 64; o++) begin
          logic [5:0] ed, ech, esrc;
          logic olen;
          ol_test_n = m[0];
          sw_run    = m[1];
          cmd_on    = 6'(c);
          open_ld   = 6'(o);
          #1;
          ed   = sw_run ? 6'(c) : 6'h0;
          olen = !ol_test_n && sw_run;
          esrc = olen ? ~ed : 6'h0;
          ech  = ed | (esrc & 6'(o));
          chk("R9 drv gating", drv_en, ed);
          chk("R10 status word", status, {1'b0, !sw_run, 7'b0, ech, 1'b0});
          chk("R11 open-load source", ol_src_en, esrc);
          @(negedge clk);
        end
      end
    end
    ol_test_n = 1; sw_run = 1; open_ld = '0; cmd_on = 6'h3F;
    tp_warn = 1;
    #1 chk("R10 warning bit", status, 16'h007F);
    tp_warn = 0;
    @(negedge clk);

    // R1/R2/R8: per-channel short delay, both selects
    for (int s = 0; s < 2; s++) begin
      for (int ch = 0; ch < 6; ch++) begin
        int lim;
        lim = s ? SC * 8 : SC;
        dly_long = s[0];
        ovc = 6'(1 << ch);
        @(negedge clk);
        ticks(lim - 1);
        ovc = '0;
        @(negedge clk);
        ovc = 6'(1 << ch);
        ticks(lim - 1);
        chk("R1 restart after early clear", drv_en, 6'h3F);
        chk("R2 not yet expired", status[13], 0);
        ticks(1);
        chk("R1 only faulty channel off", drv_en, 6'h3F & ~6'(1 << ch));
        chk("R2 flag at limit", status[13], 1);
        ovc = '0;
        pulse_srr();
        chk("R8 channel restored", drv_en, 6'h3F);
        chk("R8 flag cleared", status[13], 0);
      end
    end
    dly_long = 0;

    // R3: prewarning makes the trip immediate
    tp_warn = 1; ovc = 6'h04;
    @(negedge clk);
    chk("R3 immediate disable", drv_en, 6'h3B);
    chk("R3 flag set", status[13], 1);
    tp_warn = 0; ovc = '0;
    pulse_srr();
    chk("R3 recovered", drv_en, 6'h3F);

    // R8: reset with the short still present
    ovc = 6'h01;
    ticks(SC);
    chk("R8 tripped", drv_en, 6'h3E);
    pulse_srr();
    chk("R8 flag cleared under fault", status[13], 0);
    chk("R8 re-enabled under fault", drv_en, 6'h3F);
    ticks(SC - 1);
    chk("R8 full delay again", drv_en, 6'h3F);
    ticks(1);
    chk("R8 re-trip", drv_en, 6'h3E);
    chk("R8 flag set again", status[13], 1);
    ovc = '0;
    pulse_srr();

    // R4/R6: over-voltage, both selects
    for (int s = 0; s < 2; s++) begin
      int lim;
      lim = s ? OV * 4 : OV;
      dly_long = s[0];
      ov_det = 1;
      ticks(lim - 1);
      chk("R4 before limit", drv_en, 6'h3F);
      chk("R4 flag clear before limit", status[15], 0);
      ticks(1);
      chk("R4 all off", drv_en, 6'h00);
      chk("R4 flag set", status[15], 1);
      ov_det = 0;
      @(negedge clk);
      chk("R6 outputs back", drv_en, 6'h3F);
      chk("R6 flag sticky", status[15], 1);
      pulse_srr();
      chk("R6 flag cleared", status[15], 0);
    end

    // R5: under-voltage ignores the select bit
    for (int s = 0; s < 2; s++) begin
      dly_long = s[0];
      uv_det = 1;
      ticks(UV - 1);
      chk("R5 before limit", drv_en, 6'h3F);
      ticks(1);
      chk("R5 all off", drv_en, 6'h00);
      chk("R5 flag set", status[15], 1);
      uv_det = 0;
      @(negedge clk);
      pulse_srr();
    end

    // R6: reset during an ongoing supply fault
    dly_long = 0; ov_det = 1;
    ticks(OV);
    pulse_srr();
    chk("R6 flag cleared under fault", status[15], 0);
    chk("R6 still held off", drv_en, 6'h00);
    ticks(OV);
    chk("R6 flag set again", status[15], 1);
    ov_det = 0;
    @(negedge clk);
    pulse_srr();

    // R7: thermal shutdown latch
    tsd_det = 1;
    @(negedge clk);
    chk("R7 all ones", status, 16'hFFFF);
    chk("R7 all off", drv_en, 6'h00);
    pulse_srr();
    chk("R7 reset ignored while hot", status, 16'hFFFF);
    tsd_det = 0;
    @(negedge clk);
    chk("R7 latched after cooling", status, 16'hFFFF);
    chk("R7 still off", drv_en, 6'h00);
    pulse_srr();
    chk("R7 released", status, 16'h007E);
    chk("R7 outputs back", drv_en, 6'h3F);

    // R9: inhibit sources
    hw_run = 0;
    #1 chk("R9 pin inhibit drv", drv_en, 6'h00);
    chk("R9 pin inhibit bit", status[14], 1);
    hw_run = 1; sw_run = 0;
    #1 chk("R9 soft inhibit drv", drv_en, 6'h00);
    chk("R9 soft inhibit bit", status[14], 1);
    sw_run = 1;
    #1 chk("R9 running bit", status[14], 0);
    chk("R9 running drv", drv_en, 6'h3F);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule